// File: doc/BRIEF.md
# Dual 64-bit Parameter Register Bank with Optional Update Strobes

This block is an AXI4-Lite slave that holds two 64-bit parameters for a neighbouring processing core. Software loads each parameter as two 32-bit halves. The block drives the assembled 64-bit value to the core on a dedicated output bus, `param_a_o` or `param_b_o`.

A build-time switch, `VALID_MODE`, selects how the core learns about new values. With the switch off, the core samples the buses whenever it likes, and there is no handshake of any kind. With the switch on, each parameter also gets a control word. Writing 1 to bit 0 of that word raises a one-cycle strobe toward the core, so software can announce that both halves are now consistent.

Reserved locations read as zero and discard writes. Every access, whatever its address, ends with an OKAY response.

Top module: `dual_param_regbank`

## Requirements
- R1: Parameter A bits 31:0 live at byte address 0x10 and bits 63:32 at 0x14. Both words are readable and writable, and `param_a_o` shows {word 0x14, word 0x10}.
- R2: Parameter B bits 31:0 live at 0x1C and bits 63:32 at 0x20. Both words are readable and writable, and `param_b_o` shows {word 0x20, word 0x1C}.
- R3: Addresses 0x00, 0x04, 0x08 and 0x0C are reserved, as is every address not assigned here. Reserved addresses read as 0 and ignore writes. All read and write responses are OKAY (2'b00).
- R4: On a data word, write strobe bit n enables byte n (bits 8n+7:8n). A byte whose strobe is 0 keeps its old value.
- R5: When `VALID_MODE`=1, bit 0 of 0x18 is the update flag for A and bit 0 of 0x24 is the update flag for B. A write sets a flag only when strobe bit 0 is 1 and data bit 0 is 1. A set flag stays high for exactly one clock, and the matching `*_vld_o` output is high in that same clock. Once the pulse has ended, reading the flag returns 0.
- R6: When `VALID_MODE`=0, addresses 0x18 and 0x24 are reserved, and both `*_vld_o` outputs stay at 0.
- R7: The write address and write data may arrive in either order or in the same cycle. Each write produces exactly one write response.
- R8: While `rst` is high, all data words and flags clear to 0, and all ready and response-valid outputs are 0.
- R9: Once raised, `s_bvalid` stays high until `s_bready` is seen. Once raised, `s_rvalid` stays high with `s_rdata` unchanged until `s_rready` is seen.
- R10: A parameter output and its strobe change only on the clock edge where `s_bvalid` rises for the write that caused the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| param_a_o | output | 64 | Parameter A value |
| param_a_vld_o | output | 1 | Update strobe for A |
| param_b_o | output | 64 | Parameter B value |
| param_b_vld_o | output | 1 | Update strobe for B |

## Verification
A corrupted half-word or a wrong byte merge shows up on the 64-bit output bus in the same cycle that the write response appears. It also shows up on the next read-back of that address. A flag that fails to self-clear shows up as a strobe lasting two or more cycles, and one cycle later it shows up as a nonzero read of the control word. A broken address/data join shows up as a missing or duplicated write response. A stuck internal pending state shows up as a ready output that never returns high, which the bench sees within a few cycles of the next access.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned STRB_W       = WORD_W / 8;
  localparam int unsigned PARAM_W      = 2 * WORD_W;
  localparam int unsigned NUM_PARAMS   = 2;
  // Word index of the first parameter's low half, and word spacing per parameter.
  localparam int unsigned FIRST_WORD   = 4;
  localparam int unsigned STRIDE_WORDS = 3;
  localparam logic [1:0]  RESP_OKAY    = 2'b00;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter bit          VALID_MODE = 1'b1
)(
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_PARAMS-1:0] sel_lo,
  output logic [NUM_PARAMS-1:0] sel_hi,
  output logic [NUM_PARAMS-1:0] sel_ctl
);
  logic [ADDR_W-1:0] word_idx;
  assign word_idx = addr >> 2;

  for (genvar i = 0; i < NUM_PARAMS; i++) begin : g_slot
    localparam int unsigned LO_IDX = FIRST_WORD + STRIDE_WORDS * i;
    assign sel_lo[i] = (word_idx == ADDR_W'(LO_IDX));
    assign sel_hi[i] = (word_idx == ADDR_W'(LO_IDX + 1));
    if (VALID_MODE) begin : g_ctl
      assign sel_ctl[i] = (word_idx == ADDR_W'(LO_IDX + 2));
    end else begin : g_no_ctl
      assign sel_ctl[i] = 1'b0;
    end
  end
endmodule

// File: rtl/regbank_entry.sv
module regbank_entry
  import regbank_pkg::*;
#(
  parameter bit VALID_MODE = 1'b1
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               we_lo,
  input  logic               we_hi,
  input  logic               we_ctl,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [STRB_W-1:0]  wr_strb,
  output logic [PARAM_W-1:0] value,
  output logic               vld,
  output logic [WORD_W-1:0]  ctl_word
);
  logic [WORD_W-1:0] lo_q, hi_q;
  logic              flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      for (int b = 0; b < STRB_W; b++) begin
        if (we_lo && wr_strb[b]) lo_q[8*b +: 8] <= wr_data[8*b +: 8];
        if (we_hi && wr_strb[b]) hi_q[8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  if (VALID_MODE) begin : g_flag
    logic flag_q;
    // Self-clearing: high only in the cycle after a qualifying write.
    always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b0;
      else     flag_q <= we_ctl & wr_strb[0] & wr_data[0];
    end
    assign flag = flag_q;
  end else begin : g_no_flag
    logic unused_ctl;
    assign unused_ctl = we_ctl;
    assign flag       = 1'b0;
  end

  assign value    = {hi_q, lo_q};
  assign vld      = flag;
  assign ctl_word = {{(WORD_W-1){1'b0}}, flag};
endmodule

// File: rtl/regbank_wr_chan.sv
module regbank_wr_chan
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [WORD_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  logic aw_full_q, w_full_q, bvalid_q, awready_q, wready_q;
  logic aw_full_n, w_full_n, bvalid_n;
  logic aw_hs, w_hs;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;

  assign aw_hs = awvalid & awready_q;
  assign w_hs  = wvalid & wready_q;
  assign wr_en = aw_full_q & w_full_q & ~bvalid_q;

  always_comb begin
    aw_full_n = aw_full_q;
    w_full_n  = w_full_q;
    bvalid_n  = bvalid_q;
    if (bvalid_q && bready) bvalid_n = 1'b0;
    if (wr_en) begin
      aw_full_n = 1'b0;
      w_full_n  = 1'b0;
      bvalid_n  = 1'b1;
    end
    if (aw_hs) aw_full_n = 1'b1;
    if (w_hs)  w_full_n  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      awready_q <= 1'b0;
      wready_q  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      strb_q    <= '0;
    end else begin
      aw_full_q <= aw_full_n;
      w_full_q  <= w_full_n;
      bvalid_q  <= bvalid_n;
      awready_q <= ~aw_full_n & ~bvalid_n;
      wready_q  <= ~w_full_n & ~bvalid_n;
      if (aw_hs) addr_q <= awaddr;
      if (w_hs) begin
        data_q <= wdata;
        strb_q <= wstrb;
      end
    end
  end

  assign awready = awready_q;
  assign wready  = wready_q;
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
  assign wr_strb = strb_q;
endmodule

// File: rtl/regbank_rd_chan.sv
module regbank_rd_chan
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              arvalid,
  output logic              arready,
  output logic [WORD_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic [WORD_W-1:0] rd_word
);
  logic arready_q, rvalid_q, rvalid_n, ar_hs;
  logic [WORD_W-1:0] rdata_q;

  assign ar_hs = arvalid & arready_q;

  always_comb begin
    rvalid_n = rvalid_q;
    if (rvalid_q && rready) rvalid_n = 1'b0;
    if (ar_hs)              rvalid_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arready_q <= 1'b0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rvalid_q  <= rvalid_n;
      arready_q <= ~rvalid_n;
      if (ar_hs) rdata_q <= rd_word;
    end
  end

  assign arready = arready_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;
endmodule

// File: rtl/dual_param_regbank.sv
module dual_param_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter bit          VALID_MODE = 1'b1
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  s_awaddr,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [WORD_W-1:0]  s_wdata,
  input  logic [STRB_W-1:0]  s_wstrb,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic [1:0]         s_bresp,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [ADDR_W-1:0]  s_araddr,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [WORD_W-1:0]  s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic [PARAM_W-1:0] param_a_o,
  output logic               param_a_vld_o,
  output logic [PARAM_W-1:0] param_b_o,
  output logic               param_b_vld_o
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [STRB_W-1:0] wr_strb;
  logic [NUM_PARAMS-1:0] w_lo, w_hi, w_ctl, r_lo, r_hi, r_ctl;
  logic [PARAM_W-1:0] val [NUM_PARAMS];
  logic [WORD_W-1:0]  ctl [NUM_PARAMS];
  logic [NUM_PARAMS-1:0] vld;
  logic [WORD_W-1:0] rd_word;

  regbank_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  regbank_decode #(.ADDR_W(ADDR_W), .VALID_MODE(VALID_MODE)) u_wdec (
    .addr(wr_addr), .sel_lo(w_lo), .sel_hi(w_hi), .sel_ctl(w_ctl)
  );

  regbank_decode #(.ADDR_W(ADDR_W), .VALID_MODE(VALID_MODE)) u_rdec (
    .addr(s_araddr), .sel_lo(r_lo), .sel_hi(r_hi), .sel_ctl(r_ctl)
  );

  for (genvar i = 0; i < NUM_PARAMS; i++) begin : g_entry
    regbank_entry #(.VALID_MODE(VALID_MODE)) u_entry (
      .clk(clk), .rst(rst),
      .we_lo(wr_en & w_lo[i]),
      .we_hi(wr_en & w_hi[i]),
      .we_ctl(wr_en & w_ctl[i]),
      .wr_data(wr_data), .wr_strb(wr_strb),
      .value(val[i]), .vld(vld[i]), .ctl_word(ctl[i])
    );
  end

  // Unmatched addresses leave every select low, so they read as zero.
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_PARAMS; i++) begin
      if (r_lo[i])  rd_word = rd_word | val[i][WORD_W-1:0];
      if (r_hi[i])  rd_word = rd_word | val[i][PARAM_W-1:WORD_W];
      if (r_ctl[i]) rd_word = rd_word | ctl[i];
    end
  end

  regbank_rd_chan u_rd (
    .clk(clk), .rst(rst),
    .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .rd_word(rd_word)
  );

  assign param_a_o     = val[0];
  assign param_a_vld_o = vld[0];
  assign param_b_o     = val[1];
  assign param_b_vld_o = vld[1];
endmodule

// File: rtl/regbank_checker.sv
module regbank_checker
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
)(
  input logic               clk,
  input logic               rst,
  input logic               s_awready,
  input logic               s_wready,
  input logic               s_arready,
  input logic [1:0]         s_bresp,
  input logic               s_bvalid,
  input logic               s_bready,
  input logic [WORD_W-1:0]  s_rdata,
  input logic [1:0]         s_rresp,
  input logic               s_rvalid,
  input logic               s_rready,
  input logic [PARAM_W-1:0] param_a_o,
  input logic               param_a_vld_o,
  input logic [PARAM_W-1:0] param_b_o,
  input logic               param_b_vld_o
);
  assert_bresp_okay_R3: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> s_bresp == RESP_OKAY);
  assert_rresp_okay_R3: assert property (@(posedge clk) disable iff (rst)
    s_rvalid |-> s_rresp == RESP_OKAY);
  assert_pulse_a_R5: assert property (@(posedge clk) disable iff (rst)
    param_a_vld_o |=> !param_a_vld_o);
  assert_pulse_b_R5: assert property (@(posedge clk) disable iff (rst)
    param_b_vld_o |=> !param_b_vld_o);
  assert_strobe_at_resp_R10: assert property (@(posedge clk) disable iff (rst)
    (param_a_vld_o || param_b_vld_o) |-> $rose(s_bvalid));
  assert_quiet_a_R10: assert property (@(posedge clk) disable iff (rst)
    !$rose(s_bvalid) |-> $stable(param_a_o));
  assert_quiet_b_R10: assert property (@(posedge clk) disable iff (rst)
    !$rose(s_bvalid) |-> $stable(param_b_o));
  assert_bhold_R9: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid);
  assert_rhold_R9: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  assert_reset_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !s_awready && !s_wready && !s_arready && !s_bvalid && !s_rvalid
                   && param_a_o == '0 && param_b_o == '0);
endmodule

bind dual_param_regbank regbank_checker #(.ADDR_W(ADDR_W)) u_regbank_checker (
  .clk(clk), .rst(rst),
  .s_awready(s_awready), .s_wready(s_wready), .s_arready(s_arready),
  .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .param_a_o(param_a_o), .param_a_vld_o(param_a_vld_o),
  .param_b_o(param_b_o), .param_b_vld_o(param_b_vld_o)
);

// File: tb/dual_param_regbank_bench.sv
module dual_param_regbank_bench;
  localparam int AW = 6;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;

  logic awready, wready, bvalid, arready, rvalid, va, vb;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [63:0] pa, pb;
  logic p_awready, p_wready, p_bvalid, p_arready, p_rvalid, p_va, p_vb;
  logic [1:0] p_bresp, p_rresp;
  logic [31:0] p_rdata;
  logic [63:0] p_pa, p_pb;

  dual_param_regbank #(.ADDR_W(AW), .VALID_MODE(1'b1)) u_dual_param_regbank (
    .clk(clk), .rst(rst), .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .param_a_o(pa), .param_a_vld_o(va), .param_b_o(pb), .param_b_vld_o(vb));

  dual_param_regbank #(.ADDR_W(AW), .VALID_MODE(1'b0)) u_dual_param_regbank_plain (
    .clk(clk), .rst(rst), .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(p_awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(p_wready),
    .s_bresp(p_bresp), .s_bvalid(p_bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(p_arready),
    .s_rdata(p_rdata), .s_rresp(p_rresp), .s_rvalid(p_rvalid), .s_rready(rready),
    .param_a_o(p_pa), .param_a_vld_o(p_va), .param_b_o(p_pb), .param_b_vld_o(p_vb));

  int n_tests = 0, n_fail = 0, b_cnt = 0;
  bit finished = 0;

  function automatic void check(input bit ok, input string req,
                                input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endfunction

  // Scoreboard of read results: expected word for each instance.
  logic [31:0] q_exp[$];
  logic [31:0] q_exp_p[$];
  string       q_tag[$];

  always @(posedge clk) begin
    if (!rst && bvalid && bready) b_cnt++;
    if (!rst && rvalid && rready) begin
      if (q_exp.size() == 0) check(0, "R3 unexpected read data", {32'd0, rdata}, 64'd0);
      else begin
        logic [31:0] e, ep;
        string t;
        e = q_exp.pop_front(); ep = q_exp_p.pop_front(); t = q_tag.pop_front();
        check(rdata == e, t, {32'd0, rdata}, {32'd0, e});
        check(p_rvalid && p_rdata == ep, {t, " plain"}, {32'd0, p_rdata}, {32'd0, ep});
        check(rresp == 2'b00, "R3 rresp", {62'd0, rresp}, 64'd0);
      end
    end
  end

  logic [63:0] pre_a, pre_b, at_a, at_b;
  logic at_va, at_vb, nx_va, nx_vb, at_pva, at_pvb;

  // order: 0 address and data together, 1 address first, 2 data first
  task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d,
                           input logic [3:0] s, input int order, input bit hold_b);
    bit aw_done = 0, w_done = 0, aw_hs, w_hs;
    int c0;
    c0 = b_cnt;
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s;
    bready = !hold_b;
    awvalid = (order != 2);
    wvalid  = (order != 1);
    while (!(aw_done && w_done)) begin
      aw_hs = awvalid && awready;
      w_hs  = wvalid && wready;
      @(negedge clk);
      if (aw_hs) begin awvalid = 0; aw_done = 1; end
      if (w_hs)  begin wvalid = 0;  w_done = 1;  end
      if (aw_done && !w_done) wvalid = 1;
      if (w_done && !aw_done) awvalid = 1;
    end
    pre_a = pa; pre_b = pb;
    while (!bvalid) begin
      pre_a = pa; pre_b = pb;
      @(negedge clk);
    end
    at_a = pa; at_b = pb; at_va = va; at_vb = vb; at_pva = p_va; at_pvb = p_vb;
    check(bresp == 2'b00, "R3 bresp", {62'd0, bresp}, 64'd0);
    if (hold_b) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(bvalid, "R9 bvalid held", {63'd0, bvalid}, 64'd1);
      end
      bready = 1;
    end
    @(negedge clk);
    nx_va = va; nx_vb = vb;
    check(b_cnt == c0 + 1, "R7 one response", 64'(b_cnt - c0), 64'd1);
    @(negedge clk);
    check(!bvalid && b_cnt == c0 + 1, "R7 no extra response", 64'(b_cnt - c0), 64'd1);
  endtask

  task automatic axi_read(input logic [AW-1:0] a, input logic [31:0] e,
                          input logic [31:0] ep, input string tag, input bit hold_r);
    q_exp.push_back(e); q_exp_p.push_back(ep); q_tag.push_back(tag);
    @(negedge clk);
    araddr = a; arvalid = 1; rready = !hold_r;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    if (hold_r) begin
      logic [31:0] first;
      first = rdata;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(rvalid && rdata == first, "R9 rdata held", {32'd0, rdata}, {32'd0, first});
      end
      rready = 1;
    end
    while (rvalid) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!awready && !wready && !arready && !bvalid && !rvalid, "R8 ready/valid low in reset",
          {59'd0, awready, wready, arready, bvalid, rvalid}, 64'd0);
    check(pa == 0 && pb == 0 && !va && !vb, "R8 outputs zero in reset", pa | pb, 64'd0);
    rst = 0;
    @(negedge clk);
    axi_read(6'h10, 32'h0, 32'h0, "R8 reset read A low", 0);

    axi_write(6'h10, 32'h11223344, 4'hF, 0, 0);
    check(pre_a == 64'd0 && at_a == 64'h11223344, "R10 A changes at response", pre_a, 64'd0);
    axi_write(6'h14, 32'hAABBCCDD, 4'hF, 1, 0);
    check(pa == 64'hAABBCCDD_11223344, "R1 param A", pa, 64'hAABBCCDD_11223344);
    check(p_pa == 64'hAABBCCDD_11223344, "R1 plain param A", p_pa, 64'hAABBCCDD_11223344);
    axi_read(6'h10, 32'h11223344, 32'h11223344, "R1 read A low", 0);
    axi_read(6'h14, 32'hAABBCCDD, 32'hAABBCCDD, "R1 read A high", 0);

    axi_write(6'h1C, 32'h55667788, 4'hF, 2, 0);
    axi_write(6'h20, 32'h99000011, 4'hF, 2, 1);
    check(pb == 64'h99000011_55667788, "R2 param B", pb, 64'h99000011_55667788);
    axi_read(6'h1C, 32'h55667788, 32'h55667788, "R2 read B low", 0);
    axi_read(6'h20, 32'h99000011, 32'h99000011, "R2 read B high", 1);

    axi_write(6'h10, 32'hFFFFFFFF, 4'b0101, 1, 0);
    check(pa == 64'hAABBCCDD_11FF33FF, "R4 byte strobes", pa, 64'hAABBCCDD_11FF33FF);
    axi_read(6'h10, 32'h11FF33FF, 32'h11FF33FF, "R4 read merged word", 0);

    axi_write(6'h08, 32'hDEADBEEF, 4'hF, 0, 0);
    check(pa == 64'hAABBCCDD_11FF33FF && pb == 64'h99000011_55667788,
          "R3 reserved write ignored", pa, 64'hAABBCCDD_11FF33FF);
    axi_read(6'h08, 32'h0, 32'h0, "R3 reserved read 0x08", 0);
    axi_read(6'h00, 32'h0, 32'h0, "R3 reserved read 0x00", 0);
    axi_read(6'h3C, 32'h0, 32'h0, "R3 unassigned read 0x3C", 0);

    axi_write(6'h18, 32'h1, 4'h1, 0, 0);
    check(at_va && !at_vb, "R5 A strobe at response", {62'd0, at_va, at_vb}, 64'd2);
    check(!nx_va, "R5 A strobe one cycle", {63'd0, nx_va}, 64'd0);
    check(!at_pva && !at_pvb, "R6 plain strobes low", {62'd0, at_pva, at_pvb}, 64'd0);
    axi_read(6'h18, 32'h0, 32'h0, "R5 R6 flag A reads 0", 0);

    axi_write(6'h24, 32'h1, 4'hE, 0, 0);
    check(!at_vb, "R5 lane 0 disabled no strobe", {63'd0, at_vb}, 64'd0);
    axi_write(6'h24, 32'h2, 4'hF, 2, 0);
    check(!at_vb, "R5 data bit 0 clear no strobe", {63'd0, at_vb}, 64'd0);
    axi_write(6'h24, 32'h1, 4'hF, 1, 0);
    check(at_vb && !at_va && !nx_vb, "R5 B strobe pulse", {62'd0, at_vb, nx_vb}, 64'd2);
    check(!at_pvb, "R6 plain B strobe low", {63'd0, at_pvb}, 64'd0);
    check(pa == 64'hAABBCCDD_11FF33FF && pb == 64'h99000011_55667788,
          "R5 flag write keeps data", pb, 64'h99000011_55667788);
    axi_read(6'h24, 32'h0, 32'h0, "R5 R6 flag B reads 0", 0);

    repeat (4) @(negedge clk);
    check(q_exp.size() == 0, "R9 all reads answered", 64'(q_exp.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule